// File: doc/BRIEF.md
# Flag-Setting Data-Processing ALU

This block is the arithmetic and logic stage of a 32-bit integer datapath. It takes two operands and a 4-bit operation code. The second operand arrives already shifted, with the shifter's carry-out beside it. The block yields a registered result and a registered write-back enable. It also keeps a four-bit condition store holding the negative (N), zero (Z), carry (C) and overflow (V) flags.

The current carry flag feeds the three carry-consuming operations. A strobed operation refreshes the flags only when flag setting is requested and the destination is not the program counter. How the flags change depends on the operation's class. Bitwise operations keep V and take C from the shifter. Arithmetic operations take C from the adder's top carry and V from signed overflow. Four test/compare codes refresh the flags but never request a write-back.

Top module: `dp_alu`

## Requirements
- R1: Bitwise codes give, on `result`, AND 0000 = a&b, EOR 0001 = a^b, ORR 1100 = a|b, BIC 1110 = a&~b, MOV 1101 = b and MVN 1111 = ~b; MOV and MVN ignore `opa`.
- R2: Arithmetic codes give SUB 0010 = a-b, RSB 0011 = b-a and ADD 0100 = a+b, modulo 2^W.
- R3: Carry-using codes read the stored C flag: ADC 0101 = a+b+C, SBC 0110 = a-b+C-1 and RSC 0111 = b-a+C-1.
- R4: `result_we` is low after a strobed code 1000 to 1011 (TST, TEQ, CMP, CMN) and after any cycle with `op_valid` low. It is high after every other strobed code.
- R5: After a flag-setting bitwise operation, V keeps its old value and C equals `shift_carry`. Z is 1 exactly when the result is zero, and N equals the result's top bit.
- R6: After a flag-setting arithmetic operation, C is the carry out of the top bit, so a subtraction sets C=1 when there is no borrow. V is 1 on signed overflow. Z and N follow the result as in R5.
- R7: TST, TEQ, CMP and CMN set the flags exactly as AND, EOR, SUB and ADD would for the same operands.
- R8: The flags change only on a clock edge where `op_valid`, `set_flags` and not `dest_is_pc` are all true. Otherwise they hold.
- R9: While `rst` is high at a clock edge, the flags clear to 0000, `result` clears to zero and `result_we` goes low.
- R10: Result, enable and flags for a strobed operation appear after the next rising clock edge. `flags` is packed {N,Z,C,V} with N in bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operation strobe |
| opcode | input | 4 | Operation code |
| opa | input | W | First operand |
| opb | input | W | Second operand, already shifted |
| shift_carry | input | 1 | Carry-out of the shifter |
| set_flags | input | 1 | Request a flag update |
| dest_is_pc | input | 1 | Destination is the program counter; blocks flag update |
| result | output | W | Registered result |
| result_we | output | 1 | Registered write-back enable |
| flags | output | 4 | Stored flags {N,Z,C,V} |

## Verification
The bench builds the block with its default width of 32. This makes the signed limit 0x7FFFFFFF and the unsigned wrap at 0xFFFFFFFF directly reachable, so overflow, carry-out and no-borrow can be driven at their exact boundaries. A reference model written in 64-bit integer arithmetic predicts each result and flag set. Carry chains are run with the stored C both set and clear, so the carry-in path is covered for both values.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
    OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
    OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
    OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  function automatic logic op_is_arith(input logic [3:0] op);
    return (!op[3] && (op[2:1] != 2'b00)) || (op[3:1] == 3'b101);
  endfunction

  function automatic logic op_writes(input logic [3:0] op);
    return op[3:2] != 2'b10;
  endfunction

endpackage

// File: rtl/dp_alu_addsub.sv
module dp_alu_addsub
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         c_now,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  localparam int MSB = W - 1;

  logic [W-1:0] ina, inb;
  logic         cin;
  logic [W:0]   total;

  always_comb begin
    ina = opa;
    inb = opb;
    cin = 1'b0;
    case (alu_op_e'(op))
      OP_SUB, OP_CMP: begin inb = ~opb; cin = 1'b1; end
      OP_RSB:         begin ina = opb; inb = ~opa; cin = 1'b1; end
      OP_ADC:         cin = c_now;
      OP_SBC:         begin inb = ~opb; cin = c_now; end
      OP_RSC:         begin ina = opb; inb = ~opa; cin = c_now; end
      default:        cin = 1'b0;
    endcase
  end

  assign total = {1'b0, ina} + {1'b0, inb} + {{W{1'b0}}, cin};
  assign sum   = total[W-1:0];
  assign cout  = total[W];
  assign ovf   = (ina[MSB] == inb[MSB]) && (total[MSB] != ina[MSB]);

endmodule

// File: rtl/dp_alu_logic.sv
module dp_alu_logic
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] res
);
  always_comb begin
    case (alu_op_e'(op))
      OP_AND, OP_TST: res = opa & opb;
      OP_EOR, OP_TEQ: res = opa ^ opb;
      OP_ORR:         res = opa | opb;
      OP_MOV:         res = opb;
      OP_BIC:         res = opa & ~opb;
      OP_MVN:         res = ~opb;
      default:        res = '0;
    endcase
  end
endmodule

// File: rtl/dp_alu_flagreg.sv
module dp_alu_flagreg
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         upd,
  input  logic         arith,
  input  logic [W-1:0] res,
  input  logic         add_c,
  input  logic         add_v,
  input  logic         sh_c,
  output nzcv_t        cur
);
  nzcv_t nxt;

  always_comb begin
    nxt.n = res[W-1];
    nxt.z = (res == '0);
    nxt.c = arith ? add_c : sh_c;
    nxt.v = arith ? add_v : cur.v;
  end

  always_ff @(posedge clk) begin
    if (rst)      cur <= '0;
    else if (upd) cur <= nxt;
  end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         op_valid,
  input  logic [3:0]   opcode,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         shift_carry,
  input  logic         set_flags,
  input  logic         dest_is_pc,
  output logic [W-1:0] result,
  output logic         result_we,
  output logic [3:0]   flags
);
  nzcv_t        fl;
  logic [W-1:0] add_res, log_res, sel_res;
  logic         add_c, add_v, arith, upd;

  assign arith = op_is_arith(opcode);
  assign upd   = op_valid && set_flags && !dest_is_pc;

  dp_alu_addsub #(.W(W)) u_add (
    .op(opcode), .opa(opa), .opb(opb), .c_now(fl.c),
    .sum(add_res), .cout(add_c), .ovf(add_v)
  );

  dp_alu_logic #(.W(W)) u_log (
    .op(opcode), .opa(opa), .opb(opb), .res(log_res)
  );

  assign sel_res = arith ? add_res : log_res;

  dp_alu_flagreg #(.W(W)) u_flg (
    .clk(clk), .rst(rst), .upd(upd), .arith(arith), .res(sel_res),
    .add_c(add_c), .add_v(add_v), .sh_c(shift_carry), .cur(fl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      result_we <= 1'b0;
    end else begin
      result_we <= op_valid && op_writes(opcode);
      if (op_valid) result <= sel_res;
    end
  end

  assign flags = fl;
endmodule

// File: rtl/dp_alu_checker.sv
module dp_alu_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         op_valid,
  input logic [3:0]   opcode,
  input logic         shift_carry,
  input logic         set_flags,
  input logic         dest_is_pc,
  input logic [W-1:0] result,
  input logic         result_we,
  input logic [3:0]   flags
);
  logic upd_in, arith_in;
  assign upd_in   = op_valid && set_flags && !dest_is_pc;
  assign arith_in = (!opcode[3] && (opcode[2:1] != 2'b00)) || (opcode[3:1] == 3'b101);

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !upd_in |=> $stable(flags)); // R8
  AST_NO_WB_TEST: assert property (@(posedge clk) disable iff (rst)
    (op_valid && opcode[3:2] == 2'b10) |=> !result_we); // R4
  AST_NO_WB_IDLE: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> !result_we); // R4
  AST_LOGIC_V_KEEP: assert property (@(posedge clk) disable iff (rst)
    (upd_in && !arith_in) |=> flags[0] == $past(flags[0])); // R5
  AST_LOGIC_C_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (upd_in && !arith_in) |=> flags[1] == $past(shift_carry)); // R5
  AST_Z_FROM_RESULT: assert property (@(posedge clk) disable iff (rst)
    upd_in |=> flags[2] == (result == '0)); // R6
  AST_N_FROM_RESULT: assert property (@(posedge clk) disable iff (rst)
    upd_in |=> flags[3] == result[W-1]); // R6
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (flags == 4'b0000 && !result_we && result == '0)); // R9
endmodule

bind dp_alu dp_alu_checker #(.W(W)) u_chk (.*);

// File: tb/dp_alu_test.sv
module dp_alu_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [3:0]  opcode = 4'h0;
  logic [31:0] opa = '0, opb = '0;
  logic        shift_carry = 1'b0, set_flags = 1'b0, dest_is_pc = 1'b0;
  logic [31:0] result;
  logic        result_we;
  logic [3:0]  flags;

  int total = 0, bad = 0;
  logic [3:0] mf = 4'b0000; // model flags {N,Z,C,V}

  always #10 clk = ~clk; // 50 MHz

  dp_alu #(.W(32)) uut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .opcode(opcode), .opa(opa),
    .opb(opb), .shift_carry(shift_carry), .set_flags(set_flags),
    .dest_is_pc(dest_is_pc), .result(result), .result_we(result_we), .flags(flags)
  );

  task automatic check(input string req, input logic [36:0] got, input logic [36:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // reference model from the requirements, 64-bit integer arithmetic
  task automatic model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic sc, output logic [31:0] r, output logic [3:0] nf);
    longint ua, ub, sa, sb, s, u, bw;
    logic c, v, ar;
    ua = longint'({32'd0, a}); ub = longint'({32'd0, b});
    sa = longint'($signed(a)); sb = longint'($signed(b));
    c = sc; v = mf[0]; ar = 1'b1; r = '0; s = 0; u = 0;
    bw = mf[1] ? 0 : 1;
    case (op)
      4'h0, 4'h8: begin r = a & b; ar = 0; end
      4'h1, 4'h9: begin r = a ^ b; ar = 0; end
      4'hC: begin r = a | b; ar = 0; end
      4'hD: begin r = b; ar = 0; end
      4'hE: begin r = a & ~b; ar = 0; end
      4'hF: begin r = ~b; ar = 0; end
      4'h4, 4'hB, 4'h5: begin
        u = ua + ub + ((op == 4'h5) ? 1 - bw : 0);
        s = sa + sb + ((op == 4'h5) ? 1 - bw : 0);
        r = u[31:0]; c = u[32];
      end
      4'h2, 4'hA, 4'h6: begin
        if (op != 4'h6) bw = 0;
        r = 32'(ua - ub - bw); c = (ua >= ub + bw); s = sa - sb - bw;
      end
      default: begin // 3 RSB, 7 RSC
        if (op == 4'h3) bw = 0;
        r = 32'(ub - ua - bw); c = (ub >= ua + bw); s = sb - sa - bw;
      end
    endcase
    if (ar) v = (s > 64'sd2147483647) || (s < -64'sd2147483648);
    nf = {r[31], r == 32'd0, c, v};
  endtask

  // present one strobed op, sample after the next rising edge
  task automatic run(input string req, input logic [3:0] op, input logic [31:0] a,
                     input logic [31:0] b, input logic sc, input logic sf, input logic pc);
    logic [31:0] er;
    logic [3:0]  nf;
    logic        ewe;
    model(op, a, b, sc, er, nf);
    ewe = (op[3:2] != 2'b10);
    @(negedge clk);
    op_valid = 1; opcode = op; opa = a; opb = b; shift_carry = sc;
    set_flags = sf; dest_is_pc = pc;
    @(negedge clk);
    op_valid = 0;
    if (sf && !pc) mf = nf;
    check(req, {er, ewe, flags}, {result, result_we, mf});
  endtask

  task automatic t_reset;
    check("R9 reset state", {result, result_we, flags}, 37'd0);
  endtask

  task automatic t_logic;
    run("R1 AND", 4'h0, 32'hF0F0_1234, 32'h0FF0_FF00, 1, 1, 0);
    run("R1 EOR", 4'h1, 32'hAAAA_0000, 32'hFFFF_0000, 0, 1, 0);
    run("R1 ORR", 4'hC, 32'h8000_0001, 32'h0000_0100, 1, 1, 0);
    run("R1 BIC", 4'hE, 32'hFFFF_FFFF, 32'h0000_FFFF, 0, 1, 0);
    run("R1 MOV ignores opa", 4'hD, 32'hDEAD_BEEF, 32'h0000_0000, 1, 1, 0);
    run("R1 MVN ignores opa", 4'hF, 32'h1234_5678, 32'h0000_0000, 0, 1, 0);
  endtask

  task automatic t_arith;
    run("R2 SUB", 4'h2, 32'd100, 32'd30, 0, 1, 0);
    run("R6 SUB borrow", 4'h2, 32'd0, 32'd1, 0, 1, 0);
    run("R2 RSB", 4'h3, 32'd5, 32'd12, 0, 1, 0);
    run("R6 ADD overflow", 4'h4, 32'h7FFF_FFFF, 32'd1, 0, 1, 0);
    run("R6 ADD carry zero", 4'h4, 32'hFFFF_FFFF, 32'd1, 0, 1, 0);
  endtask

  task automatic t_carry_ops;
    run("R3 ADC with C=1", 4'h5, 32'd10, 32'd20, 0, 1, 0);
    run("R3 ADC with C=0", 4'h5, 32'd10, 32'd20, 0, 1, 0);
    run("R3 SBC with C=0", 4'h6, 32'd50, 32'd8, 0, 1, 0);
    run("R3 SBC with C=1", 4'h6, 32'd50, 32'd8, 0, 1, 0);
    run("R3 RSC with C=1", 4'h7, 32'd3, 32'd9, 0, 1, 0);
    run("R3 RSC with C=1 wrap", 4'h7, 32'h8000_0000, 32'd1, 0, 1, 0);
  endtask

  task automatic t_v_keep;
    run("R6 SUB signed overflow", 4'h2, 32'h8000_0000, 32'd1, 0, 1, 0);
    run("R5 logic keeps V", 4'h0, 32'hFFFF_FFFF, 32'h8000_0000, 1, 1, 0);
    run("R5 logic zero C=0", 4'h1, 32'h55, 32'h55, 0, 1, 0);
  endtask

  task automatic t_compare;
    run("R7 CMP equal", 4'hA, 32'd77, 32'd77, 0, 1, 0);
    run("R7 CMN", 4'hB, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 0, 1, 0);
    run("R7 TST", 4'h8, 32'h0F, 32'hF0, 1, 1, 0);
    run("R7 TEQ", 4'h9, 32'h8000_0000, 32'h1, 0, 1, 0);
  endtask

  task automatic t_suppress;
    run("R8 set_flags low", 4'h2, 32'd0, 32'd5, 0, 0, 0);
    run("R8 dest is pc", 4'h4, 32'hFFFF_FFFF, 32'd1, 1, 1, 1);
    @(negedge clk);
    check("R4 idle no write", {32'd0, result_we, flags}, {32'd0, 1'b0, mf});
    opcode = 4'h2; opa = 32'd0; opb = 32'd9; set_flags = 1; // op_valid stays low
    @(negedge clk);
    check("R8 no strobe holds flags", {32'd0, result_we, flags}, {32'd0, 1'b0, mf});
    set_flags = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog R10 got=hang exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 0;
    t_logic();
    t_arith();
    t_carry_ops();
    t_v_keep();
    t_compare();
    t_suppress();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule